// File: doc/BRIEF.md
# Packet-Filter VM Branch Unit

This block resolves control-flow instructions for a small packet-filter virtual machine. For each issued instruction it takes the 8-bit opcode, the 4-bit source-register field, the 16-bit signed offset, the 32-bit immediate, the current program counter and the two operand register values. It returns the next program counter, in units of 64-bit instruction slots, together with flags that tell the pipeline what kind of control transfer happened.

The unit handles conditional branches that compare the full 64-bit operands or only their low 32 bits, using equality, unsigned, signed and bit-test conditions. It also handles the two forms of unconditional jump, which differ in where the displacement comes from. Calls and returns are decoded and flagged but not executed. For a call to a function inside the same program, the unit also supplies the call target. Any encoding it does not recognise raises an illegal flag.

Results are registered. They appear one clock after an issue strobe, qualified by a done pulse.

Top module: `pfvm_branch_unit`

## Requirements
- R1: While reset is asserted and after its release with no issue, `done_o`, `taken_o`, `call_o`, `call_local_o`, `exit_o`, `illegal_o` and `next_pc_o` are all zero.
- R2: The opcode class in bits [2:0] selects the compare width. 3'b101 compares all 64 operand bits. 3'b110 compares only bits [31:0], treating those as the whole operand.
- R3: Opcode bit 3 picks the second operand. When it is 1 the second operand is `src_val_i`. When it is 0 the second operand is `imm_i` sign-extended to 64 bits.
- R4: Opcode bits [7:4] give the condition. 0x1 is equal and 0x5 is not equal. 0x2, 0x3, 0xA and 0xB are unsigned greater, greater-or-equal, less and less-or-equal.
- R5: Condition codes 0x6, 0x7, 0xC and 0xD are signed greater, greater-or-equal, less and less-or-equal. They use two's complement at the selected compare width. For example, opcode 0x7E is a signed greater-or-equal on the low 32 bits of two registers.
- R6: Condition code 0x4 is a bit test. It is taken when the bitwise AND of the two operands, at the selected width, is nonzero.
- R7: A taken branch gives next PC = PC + 1 + the sign-extended displacement. A not-taken branch gives PC + 1. Both results wrap modulo 2^PC_W.
- R8: Code 0x0 is an unconditional jump and requires opcode bit 3 = 0. In class 3'b101 its displacement is the 16-bit offset. In class 3'b110 its displacement is the 32-bit immediate.
- R9: Code 0x8 in class 3'b101 with bit 3 = 0 is a call, and raises `call_o` with next PC = PC + 1. A source field of 0 or 2 means an external call. A source field of 1 is a local call: it also raises `call_local_o`, and next PC = PC + 1 + immediate. Any other source field is illegal.
- R10: Code 0x9 in class 3'b101 with bit 3 = 0 raises `exit_o` with next PC = PC + 1.
- R11: The following raise `illegal_o` with `taken_o` low and next PC = PC + 1: any class other than 3'b101 or 3'b110, codes 0xE and 0xF, call or exit outside class 3'b101 or with bit 3 = 1, and an unconditional jump with bit 3 = 1.
- R12: Results appear on the clock edge after `issue_i` is high, with `done_o` high for that cycle. When `done_o` is low, all flags are low and `next_pc_o` holds its last value.
- R13: At most one of `taken_o`, `call_o`, `exit_o` and `illegal_o` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction presented this cycle |
| opcode_i | input | 8 | Instruction opcode |
| src_fld_i | input | 4 | Source-register field (call kind for calls) |
| offset_i | input | 16 | Signed 16-bit offset |
| imm_i | input | 32 | Signed 32-bit immediate |
| pc_i | input | PC_W | Current program counter (slots) |
| dst_val_i | input | XLEN | Destination register value |
| src_val_i | input | XLEN | Source register value |
| done_o | output | 1 | Result valid |
| next_pc_o | output | PC_W | Next program counter |
| taken_o | output | 1 | Branch or jump taken |
| call_o | output | 1 | Call instruction |
| call_local_o | output | 1 | Call to a function in the same program |
| exit_o | output | 1 | Return instruction |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
The bench builds the unit with XLEN = 64 and PC_W = 20. With a narrow 20-bit program counter, wraparound in both directions is easy to reach. A PC of 0xFFFFF steps to 0, and a large negative displacement folds back into the top of the address space. With the full 64-bit operand width, the bench can pick operand pairs whose upper and lower halves disagree. Each such pair gives one outcome in the 64-bit class and the opposite in the 32-bit class, and the same holds for signed versus unsigned and for sign-extended versus zero-extended immediates.

// File: rtl/pfvm_br_pkg.sv
package pfvm_br_pkg;

  localparam logic [2:0] CLS_WIDE   = 3'b101;
  localparam logic [2:0] CLS_NARROW = 3'b110;

  typedef enum logic [3:0] {
    CC_JA  = 4'h0, CC_EQ  = 4'h1, CC_UGT = 4'h2, CC_UGE = 4'h3,
    CC_SET = 4'h4, CC_NE  = 4'h5, CC_SGT = 4'h6, CC_SGE = 4'h7,
    CC_CALL = 4'h8, CC_EXIT = 4'h9,
    CC_ULT = 4'hA, CC_ULE = 4'hB, CC_SLT = 4'hC, CC_SLE = 4'hD,
    CC_RSV_E = 4'hE, CC_RSV_F = 4'hF
  } cond_e;

  typedef struct packed {
    logic  is_cond;
    logic  is_ja;
    logic  is_call;
    logic  is_local;
    logic  is_exit;
    logic  bad;
    logic  narrow;
    logic  use_reg;
    cond_e cond;
  } br_dec_t;

  typedef struct packed {
    logic eq;
    logic ult;
    logic slt;
    logic any;
  } cmp_flags_t;

  // Map relation flags onto a condition code.
  function automatic logic cond_hit(cond_e c, cmp_flags_t f);
    case (c)
      CC_EQ:   return f.eq;
      CC_NE:   return !f.eq;
      CC_UGT:  return !f.ult && !f.eq;
      CC_UGE:  return !f.ult;
      CC_ULT:  return f.ult;
      CC_ULE:  return f.ult || f.eq;
      CC_SGT:  return !f.slt && !f.eq;
      CC_SGE:  return !f.slt;
      CC_SLT:  return f.slt;
      CC_SLE:  return f.slt || f.eq;
      CC_SET:  return f.any;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pfvm_br_decode.sv
module pfvm_br_decode
  import pfvm_br_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [3:0] src_fld,
  output br_dec_t    dec
);
  logic [2:0] cls;
  logic [3:0] code;
  logic       xsel;
  logic       jmp_cls;
  logic       wide_k;

  assign cls     = opcode[2:0];
  assign code    = opcode[7:4];
  assign xsel    = opcode[3];
  assign jmp_cls = (cls == CLS_WIDE) || (cls == CLS_NARROW);
  assign wide_k  = (cls == CLS_WIDE) && !xsel;

  always_comb begin
    dec          = '0;
    dec.cond     = cond_e'(code);
    dec.narrow   = (cls == CLS_NARROW);
    dec.use_reg  = xsel;
    if (!jmp_cls) begin
      dec.bad = 1'b1;
    end else begin
      case (cond_e'(code))
        CC_JA: begin
          dec.is_ja = !xsel;
          dec.bad   = xsel;
        end
        CC_EQ, CC_NE, CC_UGT, CC_UGE, CC_ULT, CC_ULE,
        CC_SGT, CC_SGE, CC_SLT, CC_SLE, CC_SET: dec.is_cond = 1'b1;
        CC_CALL: begin
          if (wide_k && (src_fld <= 4'd2)) begin
            dec.is_call  = 1'b1;
            dec.is_local = (src_fld == 4'd1);
          end else begin
            dec.bad = 1'b1;
          end
        end
        CC_EXIT: begin
          dec.is_exit = wide_k;
          dec.bad     = !wide_k;
        end
        default: dec.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pfvm_br_compare.sv
module pfvm_br_compare
  import pfvm_br_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            narrow,
  output cmp_flags_t      flags
);
  localparam int HALF = XLEN / 2;

  function automatic cmp_flags_t rel_full(logic [XLEN-1:0] x, logic [XLEN-1:0] y);
    cmp_flags_t r;
    r.eq  = (x == y);
    r.ult = (x < y);
    r.slt = ($signed(x) < $signed(y));
    r.any = |(x & y);
    return r;
  endfunction

  function automatic cmp_flags_t rel_half(logic [HALF-1:0] x, logic [HALF-1:0] y);
    cmp_flags_t r;
    r.eq  = (x == y);
    r.ult = (x < y);
    r.slt = ($signed(x) < $signed(y));
    r.any = |(x & y);
    return r;
  endfunction

  cmp_flags_t f_full;
  cmp_flags_t f_half;

  assign f_full = rel_full(a, b);
  assign f_half = rel_half(a[HALF-1:0], b[HALF-1:0]);
  assign flags  = narrow ? f_half : f_full;
endmodule

// File: rtl/pfvm_br_target.sv
module pfvm_br_target #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic [31:0]     disp,
  output logic [PC_W-1:0] pc_inc,
  output logic [PC_W-1:0] pc_dst
);
  logic [PC_W-1:0] disp_x;

  generate
    if (PC_W > 32) begin : g_ext
      assign disp_x = {{(PC_W-32){disp[31]}}, disp};
    end else if (PC_W == 32) begin : g_same
      assign disp_x = disp;
    end else begin : g_trunc
      assign disp_x = disp[PC_W-1:0];
    end
  endgenerate

  function automatic logic [PC_W-1:0] add_wrap(logic [PC_W-1:0] x, logic [PC_W-1:0] y);
    return x + y;
  endfunction

  assign pc_inc = add_wrap(pc, PC_W'(1));
  assign pc_dst = add_wrap(pc_inc, disp_x);
endmodule

// File: rtl/pfvm_branch_unit.sv
module pfvm_branch_unit
  import pfvm_br_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [7:0]      opcode_i,
  input  logic [3:0]      src_fld_i,
  input  logic [15:0]     offset_i,
  input  logic [31:0]     imm_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [XLEN-1:0] dst_val_i,
  input  logic [XLEN-1:0] src_val_i,
  output logic            done_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            taken_o,
  output logic            call_o,
  output logic            call_local_o,
  output logic            exit_o,
  output logic            illegal_o
);
  br_dec_t         dec;
  cmp_flags_t      rel;
  logic [XLEN-1:0] opnd_b;
  logic [31:0]     disp;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_dst;
  logic            cond_true;
  logic            taken_w;
  logic            redirect_w;
  logic [PC_W-1:0] npc_w;

  pfvm_br_decode u_dec (
    .opcode  (opcode_i),
    .src_fld (src_fld_i),
    .dec     (dec)
  );

  assign opnd_b = dec.use_reg ? src_val_i
                              : {{(XLEN-32){imm_i[31]}}, imm_i};

  pfvm_br_compare #(.XLEN(XLEN)) u_cmp (
    .a      (dst_val_i),
    .b      (opnd_b),
    .narrow (dec.narrow),
    .flags  (rel)
  );

  // Displacement source: immediate for narrow-class jump and local call.
  assign disp = ((dec.is_ja && dec.narrow) || dec.is_local)
              ? imm_i : {{16{offset_i[15]}}, offset_i};

  pfvm_br_target #(.PC_W(PC_W)) u_tgt (
    .pc     (pc_i),
    .disp   (disp),
    .pc_inc (pc_inc),
    .pc_dst (pc_dst)
  );

  assign cond_true  = cond_hit(dec.cond, rel);
  assign taken_w    = dec.is_ja || (dec.is_cond && cond_true);
  assign redirect_w = taken_w || dec.is_local;
  assign npc_w      = redirect_w ? pc_dst : pc_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      next_pc_o    <= '0;
      taken_o      <= 1'b0;
      call_o       <= 1'b0;
      call_local_o <= 1'b0;
      exit_o       <= 1'b0;
      illegal_o    <= 1'b0;
    end else begin
      done_o       <= issue_i;
      taken_o      <= issue_i && taken_w;
      call_o       <= issue_i && dec.is_call;
      call_local_o <= issue_i && dec.is_local;
      exit_o       <= issue_i && dec.is_exit;
      illegal_o    <= issue_i && dec.bad;
      if (issue_i) next_pc_o <= npc_w;
    end
  end
endmodule

// File: rtl/pfvm_branch_unit_chk.sv
module pfvm_branch_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic [7:0]      opcode_i,
  input logic [PC_W-1:0] pc_i,
  input logic            done_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            taken_o,
  input logic            call_o,
  input logic            call_local_o,
  input logic            exit_o,
  input logic            illegal_o
);
  // R13
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot0({taken_o, call_o, exit_o, illegal_o}));

  // R12
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !(taken_o || call_o || call_local_o || exit_o || illegal_o));

  // R12
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(next_pc_o));

  // R12
  issue_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> done_o);

  // R9
  local_is_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_local_o |-> call_o);

  // R11
  illegal_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !$isunknown(pc_i)) ##1 (done_o && illegal_o)
      |-> next_pc_o == PC_W'($past(pc_i) + PC_W'(1)));

  // R10
  exit_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i ##1 (done_o && exit_o) |-> next_pc_o == PC_W'($past(pc_i) + PC_W'(1)));

  // R8
  wide_ja_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && opcode_i == 8'h05) |=> taken_o);
endmodule

bind pfvm_branch_unit pfvm_branch_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .issue_i      (issue_i),
  .opcode_i     (opcode_i),
  .pc_i         (pc_i),
  .done_o       (done_o),
  .next_pc_o    (next_pc_o),
  .taken_o      (taken_o),
  .call_o       (call_o),
  .call_local_o (call_local_o),
  .exit_o       (exit_o),
  .illegal_o    (illegal_o)
);

// File: tb/test_pfvm_branch_unit.sv
module test_pfvm_branch_unit;
  localparam int XLEN = 64;
  localparam int PC_W = 20;

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  op;
    logic [3:0]  sf;
    logic [15:0] off;
    logic [31:0] imm;
    logic [19:0] pc;
    logic [63:0] dst;
    logic [63:0] src;
    logic [4:0]  fl;   // {taken, call, local, exit, illegal}
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    {4'd4, 8'h1d,4'h0,16'h0010,32'h0,       20'h00100,64'h123456789abcdef0,64'h123456789abcdef0,5'b10000}, // R4 eq
    {4'd2, 8'h1d,4'h0,16'h0010,32'h0,       20'h00100,64'h0000000100000005,64'h0000000200000005,5'b00000}, // R2 wide
    {4'd2, 8'h1e,4'h0,16'hfffe,32'h0,       20'h00050,64'h0000000100000005,64'h0000000200000005,5'b10000}, // R2 narrow
    {4'd4, 8'h25,4'h0,16'h0004,32'h1,       20'h00010,64'hffffffffffffffff,64'h0,5'b10000},                // R4 ugt
    {4'd5, 8'h65,4'h0,16'h0004,32'h1,       20'h00010,64'hffffffffffffffff,64'h0,5'b00000},                // R5 sgt
    {4'd3, 8'ha5,4'h0,16'h0008,32'hffffffff,20'h00020,64'hffffffff00000000,64'h0,5'b10000},                // R3 sext imm
    {4'd5, 8'h7e,4'h0,16'h0003,32'h0,       20'h00030,64'h0000000080000000,64'h1,5'b00000},                // R5 0x7e
    {4'd5, 8'h7e,4'h0,16'h0003,32'h0,       20'h00030,64'h5,64'h00000000ffffffff,5'b10000},                // R5 0x7e
    {4'd6, 8'h45,4'h0,16'h0003,32'h0000000f,20'h00030,64'hf0,64'h0,5'b00000},                              // R6
    {4'd6, 8'h4d,4'h0,16'h0020,32'h0,       20'h00040,64'h0000000100000000,64'h0000000100000000,5'b10000}, // R6 wide
    {4'd6, 8'h4e,4'h0,16'h0020,32'h0,       20'h00040,64'h0000000100000000,64'h0000000100000000,5'b00000}, // R6 narrow
    {4'd4, 8'h55,4'h0,16'h0020,32'h3,       20'h00040,64'h3,64'h0,5'b00000},                               // R4 ne
    {4'd4, 8'h3d,4'h0,16'h0001,32'h0,       20'h00040,64'h7,64'h7,5'b10000},                               // R4 uge
    {4'd4, 8'hbd,4'h0,16'h0001,32'h0,       20'h00040,64'h8,64'h7,5'b00000},                               // R4 ule
    {4'd5, 8'hc5,4'h0,16'h0002,32'hfffffffe,20'h00060,64'hfffffffffffffffb,64'h0,5'b10000},                // R5 slt
    {4'd2, 8'hd6,4'h0,16'h0002,32'h2,       20'h00060,64'hffffffff00000002,64'h0,5'b10000},                // R2 sle narrow
    {4'd8, 8'h05,4'h0,16'h0100,32'h7fffffff,20'h00200,64'h0,64'h0,5'b10000},                               // R8 wide ja
    {4'd8, 8'h06,4'h0,16'h0005,32'hffffff00,20'h00400,64'h0,64'h0,5'b10000},                               // R8 narrow ja
    {4'd11,8'h0d,4'h0,16'h0005,32'h0,       20'h00400,64'h0,64'h0,5'b00001},                               // R11 ja reg
    {4'd9, 8'h85,4'h0,16'h0000,32'h12345678,20'h00700,64'h0,64'h0,5'b01000},                               // R9 helper
    {4'd9, 8'h85,4'h1,16'h0000,32'h00000010,20'h01000,64'h0,64'h0,5'b01100},                               // R9 local
    {4'd9, 8'h85,4'h2,16'h0000,32'h00000010,20'h01000,64'h0,64'h0,5'b01000},                               // R9 type id
    {4'd9, 8'h85,4'h3,16'h0000,32'h00000010,20'h01000,64'h0,64'h0,5'b00001},                               // R9 bad kind
    {4'd11,8'h86,4'h0,16'h0000,32'h0,       20'h01000,64'h0,64'h0,5'b00001},                               // R11
    {4'd11,8'h8d,4'h0,16'h0000,32'h0,       20'h01000,64'h0,64'h0,5'b00001},                               // R11
    {4'd10,8'h95,4'h0,16'h0040,32'h0,       20'h02000,64'h0,64'h0,5'b00010},                               // R10
    {4'd11,8'h96,4'h0,16'h0040,32'h0,       20'h02000,64'h0,64'h0,5'b00001},                               // R11
    {4'd11,8'he5,4'h0,16'h0040,32'h0,       20'h02000,64'h0,64'h0,5'b00001},                               // R11
    {4'd11,8'hf6,4'h0,16'h0040,32'h0,       20'h02000,64'h0,64'h0,5'b00001},                               // R11
    {4'd11,8'h07,4'h0,16'h0040,32'h0,       20'h02000,64'h0,64'h0,5'b00001},                               // R11 class
    {4'd11,8'h1c,4'h0,16'h0040,32'h0,       20'h02000,64'h0,64'h0,5'b00001},                               // R11 class
    {4'd7, 8'h15,4'h0,16'h0000,32'h0,       20'hfffff,64'h0,64'h0,5'b10000},                               // R7 wrap
    {4'd7, 8'h55,4'h0,16'h0000,32'h0,       20'hfffff,64'h0,64'h0,5'b00000},                               // R7 wrap
    {4'd7, 8'h05,4'h0,16'h8000,32'h0,       20'h00010,64'h0,64'h0,5'b10000},                               // R7 neg
    {4'd9, 8'h85,4'h1,16'h0000,32'hfffffff0,20'h00100,64'h0,64'h0,5'b01100}                                // R9 neg
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            issue_i = 1'b0;
  logic [7:0]      opcode_i = '0;
  logic [3:0]      src_fld_i = '0;
  logic [15:0]     offset_i = '0;
  logic [31:0]     imm_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [XLEN-1:0] dst_val_i = '0;
  logic [XLEN-1:0] src_val_i = '0;
  logic            done_o;
  logic [PC_W-1:0] next_pc_o;
  logic            taken_o, call_o, call_local_o, exit_o, illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  pfvm_branch_unit #(.XLEN(XLEN), .PC_W(PC_W)) i_pfvm_branch_unit (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
    .src_fld_i(src_fld_i), .offset_i(offset_i), .imm_i(imm_i), .pc_i(pc_i),
    .dst_val_i(dst_val_i), .src_val_i(src_val_i), .done_o(done_o),
    .next_pc_o(next_pc_o), .taken_o(taken_o), .call_o(call_o),
    .call_local_o(call_local_o), .exit_o(exit_o), .illegal_o(illegal_o)
  );

  function automatic logic [PC_W-1:0] exp_pc(vec_t v);
    logic [63:0] d;
    logic [63:0] s;
    if (v.op == 8'h06 || v.fl[2]) d = {{32{v.imm[31]}}, v.imm};
    else                          d = {{48{v.off[15]}}, v.off};
    s = {44'd0, v.pc} + 64'd1;
    if (v.fl[4] || v.fl[2]) s = s + d;
    return s[PC_W-1:0];
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [PC_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {25'd0, done_o, taken_o, call_o, call_local_o, exit_o, illegal_o, 1'b0},
          32'd0);
    check("R1 reset pc", 32'(next_pc_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {26'd0, done_o, taken_o, call_o, call_local_o, exit_o, illegal_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      opcode_i  = TBL[i].op;
      src_fld_i = TBL[i].sf;
      offset_i  = TBL[i].off;
      imm_i     = TBL[i].imm;
      pc_i      = TBL[i].pc;
      dst_val_i = TBL[i].dst;
      src_val_i = TBL[i].src;
      issue_i   = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d flags vec %0d", TBL[i].req, i),
            {26'd0, done_o, taken_o, call_o, call_local_o, exit_o, illegal_o},
            {26'd0, 1'b1, TBL[i].fl});
      check($sformatf("R%0d next_pc vec %0d", TBL[i].req, i),
            32'(next_pc_o), 32'(exp_pc(TBL[i])));
    end

    // R12: idle cycles keep flags low and next PC steady
    held    = next_pc_o;
    issue_i = 1'b0;
    pc_i    = 20'h0abcd;
    opcode_i = 8'h05;
    @(negedge clk);
    check("R12 idle flags", {26'd0, done_o, taken_o, call_o, call_local_o, exit_o, illegal_o}, 32'd0);
    @(negedge clk);
    check("R12 idle hold", 32'(next_pc_o), 32'(held));

    // R13 and R12: one-cycle latency on a fresh issue after idle
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    check("R12 latency", {26'd0, done_o, taken_o, call_o, call_local_o, exit_o, illegal_o},
          {26'd0, 6'b110000});
    check("R8 wide ja pc", 32'(next_pc_o), 32'(20'h0abcd + 20'h1));
    finish_run();
  end
endmodule